// File: doc/BRIEF.md
# Convolutional Interleaver Read-Address Generator

This block drives the address side of a convolutional interleaver whose symbol store is only ever written in ascending order. Each accepted input symbol is given the next write address of a circular buffer. The interleaving delay is produced entirely by the read side. In every slot the block selects a commutator branch in round-robin order. It then issues the read address of the earlier symbol that this branch must output in that slot. The store itself is outside the block. A synchronous RAM sits beside it, takes the write address together with the symbol, and returns the symbol at the read address one cycle later.

The block has a parameter for the number of branches and one for the per-branch delay unit. Branch `b` delays its own sub-stream by `b × UNIT` symbols. In the merged stream this is a distance of `b × UNIT × N_BR` symbols, so a fixed write order combined with a moving read offset gives the same output as one shift register per branch. The block flags slots whose target symbol has not yet been written since reset and suppresses their read strobe. It also marks the write that opens each new storage row, so that a row-oriented memory controller can see the row boundaries.

Top module: `cil_rdaddr_gen`

## Requirements
- R1: The cycle after `in_valid` is sampled high, `wr_en` is high and `wr_addr` holds the slot index since reset, modulo `2^AW`. Writes therefore fall on consecutive addresses starting at 0, and the address wraps from `2^AW-1` to 0.
- R2: Slot `n` (counted from 0 since reset) belongs to branch `n mod N_BR`. This value is presented on `rd_branch` in the same cycle as that slot's `wr_en`.
- R3: When a slot's `rd_en` is high, `rd_addr` equals `(wr_addr − branch × UNIT × N_BR) mod 2^AW`.
- R4: Branch 0 has no delay. Its read is always enabled and its `rd_addr` equals the `wr_addr` of the same slot, so the memory must forward a read that coincides with a write.
- R5: Slot `n` of branch `b` has `rd_en` low while `n < b × UNIT × N_BR` (warm-up) and high otherwise.
- R6: A cycle with `in_valid` low gives `wr_en`, `rd_en` and `wr_row_start` all low in the next cycle. It also leaves the slot count, the branch and the addresses of later slots unchanged.
- R7: `AW` is the smallest width for which `2^AW ≥ (N_BR−1) × UNIT × N_BR + 1`. A RAM of `2^AW` entries driven by these addresses returns, for each branch `b`, the symbol that entered that branch `b × UNIT` branch-slots earlier.
- R8: `wr_row_start` is high together with `wr_en` exactly on slots whose index since reset is a multiple of `ROW_LEN`, so that it marks the first write of every storage row.
- R9: While `rst` is high and in the first cycle after it, all outputs are low. After reset, the slot count, branch, write address and warm-up all restart from zero.
- R10: The outputs are registered and appear exactly one cycle after the `in_valid` that caused them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | One input symbol is presented in this cycle |
| wr_en | output | 1 | Write strobe for the symbol accepted in the previous cycle |
| wr_addr | output | AW | Sequential write address |
| wr_row_start | output | 1 | This write opens a new storage row |
| rd_en | output | 1 | Read strobe; low during warm-up |
| rd_addr | output | AW | Read address for the current branch |
| rd_branch | output | BW | Commutator branch of the current slot |

## Verification
The bench builds the block with four branches, a delay unit of 3 and a row length of 5. The longest delay is then 36 symbols, held in a 64-entry buffer. Address wrap, warm-up of the slowest branch and the end of warm-up are therefore all reached within a few hundred slots. The row length is not a power of two, so the separate row counter is used. Random gaps in `in_valid`, together with a reset in mid-stream, show that idle cycles leave the state unchanged and that the warm-up restarts. The symbols read back from a model RAM are compared with a model built from one shift register per branch.

// File: rtl/cil_pkg.sv
package cil_pkg;

  // Largest distance, in merged-stream symbols, between a write and its read.
  function automatic int max_delay(input int nbr, input int unit);
    return (nbr - 1) * unit * nbr;
  endfunction

  // Address width: buffer must hold max_delay + 1 symbols, power of two.
  function automatic int addr_w(input int nbr, input int unit);
    int w;
    w = $clog2(max_delay(nbr, unit) + 1);
    return (w < 1) ? 1 : w;
  endfunction

  function automatic int branch_w(input int nbr);
    return (nbr > 1) ? $clog2(nbr) : 1;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cil_commutator.sv
module cil_commutator #(
  parameter int N_BR = 40,
  parameter int UNIT = 200,
  parameter int AW   = 19,
  parameter int BW   = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [BW-1:0] branch,
  output logic [AW-1:0] off
);

  localparam int            STEP   = UNIT * N_BR;
  localparam logic [BW-1:0] LAST   = BW'(N_BR - 1);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic at_last;
  assign at_last = (branch == LAST);

  // Branch index and its read offset (branch * UNIT * N_BR) move together;
  // the offset is accumulated so no multiplier sits on the read path.
  always_ff @(posedge clk) begin
    if (rst) begin
      branch <= '0;
      off    <= '0;
    end else if (adv) begin
      if (at_last) begin
        branch <= '0;
        off    <= '0;
      end else begin
        branch <= branch + 1'b1;
        off    <= off + STEP_V;
      end
    end
  end

  AST_RR_WRAP: assert property (@(posedge clk) disable iff (rst)
    adv && at_last |=> branch == '0 && off == '0); // R2

  AST_RR_STEP: assert property (@(posedge clk) disable iff (rst)
    adv && !at_last |=> branch == $past(branch) + 1'b1); // R2

  AST_RR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(branch) && $stable(off)); // R6

endmodule

// File: rtl/cil_wr_ptr.sv
module cil_wr_ptr #(
  parameter int AW      = 19,
  parameter int ROW_LEN = 256,
  parameter int MAXD    = 312000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] fill,
  output logic          wr_en_q,
  output logic [AW-1:0] wr_addr_q,
  output logic          row_start_q
);

  localparam logic [AW-1:0] FILL_MAX = AW'(MAXD);

  logic row_now;

  // Row-boundary detection: choose the cheapest form the parameters allow.
  generate
    if (ROW_LEN <= 1) begin : g_row_every
      assign row_now = 1'b1;
    end else if (cil_pkg::is_pow2(ROW_LEN) && (ROW_LEN <= (1 << AW))) begin : g_row_bits
      localparam int LW = $clog2(ROW_LEN);
      assign row_now = (wptr[LW-1:0] == '0);
    end else begin : g_row_cnt
      localparam int            CW      = $clog2(ROW_LEN);
      localparam logic [CW-1:0] COL_END = CW'(ROW_LEN - 1);
      logic [CW-1:0] col;
      always_ff @(posedge clk) begin
        if (rst) begin
          col <= '0;
        end else if (adv) begin
          col <= (col == COL_END) ? '0 : col + 1'b1;
        end
      end
      assign row_now = (col == '0);
    end
  endgenerate

  // Next write address and warm-up depth (slots since reset, saturating).
  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      fill <= '0;
    end else if (adv) begin
      wptr <= wptr + 1'b1;
      if (fill != FILL_MAX) fill <= fill + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q     <= 1'b0;
      wr_addr_q   <= '0;
      row_start_q <= 1'b0;
    end else begin
      wr_en_q     <= adv;
      row_start_q <= adv && row_now;
      if (adv) wr_addr_q <= wptr;
    end
  end

  AST_WR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    adv |=> wr_en_q); // R10

  AST_WR_CONSEC: assert property (@(posedge clk) disable iff (rst)
    wr_en_q && $past(wr_en_q) |-> wr_addr_q == AW'($past(wr_addr_q) + 1'b1)); // R1

  AST_FILL_MONO: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> fill >= $past(fill)); // R5

  AST_ROW_WITH_WR: assert property (@(posedge clk) disable iff (rst)
    row_start_q |-> wr_en_q); // R8

endmodule

// File: rtl/cil_rd_gen.sv
module cil_rd_gen #(
  parameter int AW = 19,
  parameter int BW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic [AW-1:0] wptr,
  input  logic [AW-1:0] off,
  input  logic [AW-1:0] fill,
  input  logic [BW-1:0] branch,
  output logic          rd_en_q,
  output logic [AW-1:0] rd_addr_q,
  output logic [BW-1:0] rd_branch_q
);

  logic          ready;
  logic [AW-1:0] target;

  // The target symbol exists once at least 'off' symbols precede this slot.
  assign ready  = (fill >= off);
  assign target = wptr - off;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_en_q     <= 1'b0;
      rd_addr_q   <= '0;
      rd_branch_q <= '0;
    end else begin
      rd_en_q <= adv && ready;
      if (adv) begin
        rd_addr_q   <= target;
        rd_branch_q <= branch;
      end
    end
  end

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> !rd_en_q && $stable(rd_addr_q)); // R6

endmodule

// File: rtl/cil_rdaddr_gen.sv
module cil_rdaddr_gen #(
  parameter  int N_BR    = 40,
  parameter  int UNIT    = 200,
  parameter  int ROW_LEN = 256,
  localparam int AW      = cil_pkg::addr_w(N_BR, UNIT),
  localparam int BW      = cil_pkg::branch_w(N_BR)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          wr_row_start,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic [BW-1:0] rd_branch
);

  localparam int MAXD = cil_pkg::max_delay(N_BR, UNIT);

  logic [BW-1:0] branch;
  logic [AW-1:0] off;
  logic [AW-1:0] wptr;
  logic [AW-1:0] fill;

  cil_commutator #(
    .N_BR(N_BR), .UNIT(UNIT), .AW(AW), .BW(BW)
  ) u_comm (
    .clk(clk), .rst(rst), .adv(in_valid),
    .branch(branch), .off(off)
  );

  cil_wr_ptr #(
    .AW(AW), .ROW_LEN(ROW_LEN), .MAXD(MAXD)
  ) u_wr (
    .clk(clk), .rst(rst), .adv(in_valid),
    .wptr(wptr), .fill(fill),
    .wr_en_q(wr_en), .wr_addr_q(wr_addr), .row_start_q(wr_row_start)
  );

  cil_rd_gen #(
    .AW(AW), .BW(BW)
  ) u_rd (
    .clk(clk), .rst(rst), .adv(in_valid),
    .wptr(wptr), .off(off), .fill(fill), .branch(branch),
    .rd_en_q(rd_en), .rd_addr_q(rd_addr), .rd_branch_q(rd_branch)
  );

  AST_BR0_SAME: assert property (@(posedge clk) disable iff (rst)
    wr_en && rd_branch == '0 |-> rd_en && rd_addr == wr_addr); // R4

  AST_RD_WITH_WR: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> wr_en); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !wr_en && !rd_en && !wr_row_start); // R6

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !wr_en && !rd_en && !wr_row_start); // R9

endmodule

// File: tb/tb_cil_rdaddr_gen.sv
`timescale 1ns/1ps
module tb_cil_rdaddr_gen;

  localparam int N    = 4;
  localparam int U    = 3;
  localparam int ROW  = 5;
  localparam int D    = U * N;
  localparam int AW   = 6;
  localparam int BW   = 2;
  localparam int SZ   = 1 << AW;
  localparam int SRD  = (N - 1) * U;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [7:0]    in_data = '0;
  logic          wr_en, wr_row_start, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [BW-1:0] rd_branch;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cil_rdaddr_gen #(.N_BR(N), .UNIT(U), .ROW_LEN(ROW)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_row_start(wr_row_start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_branch(rd_branch)
  );

  // Model RAM with write-first forwarding; symbol delayed to match wr_en.
  logic [7:0] ram [SZ];
  logic [7:0] sym_q = '0;
  logic [7:0] rdata = '0;
  always @(posedge clk) begin
    if (in_valid) sym_q <= in_data;
    if (wr_en) ram[wr_addr] <= sym_q;
    if (rd_en) rdata <= (wr_en && wr_addr == rd_addr) ? sym_q : ram[rd_addr];
  end

  // Reference: one shift register per branch.
  logic [7:0] sr [N][SRD];
  int fillb [N];
  int n_slot;

  bit e1_v, e1_row, e1_rd, e2_v, e2_rd, e2_mv;
  int e1_wa, e1_ra, e1_br;
  logic [7:0] e1_dat, e2_dat;
  bit e1_mv;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    n_slot = 0;
    for (int b = 0; b < N; b++) fillb[b] = 0;
    e1_v = 1'b0; e2_v = 1'b0;
  endtask

  task automatic cycle(input bit v, input logic [7:0] d);
    int b;
    // Address-side outputs of the slot driven one cycle ago (R10).
    if (e1_v) begin
      chk(wr_en == 1'b1, "R1", "wr_en", int'(wr_en), 1);
      chk(int'(wr_addr) == e1_wa, "R1", "wr_addr", int'(wr_addr), e1_wa);
      chk(int'(rd_branch) == e1_br, "R2", "rd_branch", int'(rd_branch), e1_br);
      chk(rd_en == e1_rd, (e1_br == 0) ? "R4" : "R5", "rd_en", int'(rd_en), int'(e1_rd));
      if (e1_rd) chk(int'(rd_addr) == e1_ra, "R3", "rd_addr", int'(rd_addr), e1_ra);
      chk(wr_row_start == e1_row, "R8", "wr_row_start", int'(wr_row_start), int'(e1_row));
    end else begin
      chk(!wr_en && !rd_en && !wr_row_start, "R6", "idle strobes",
          int'({wr_en, rd_en, wr_row_start}), 0);
    end
    // Data read back from the RAM for the slot two cycles ago.
    if (e2_v && e2_rd && e2_mv)
      chk(rdata == e2_dat, "R7", "read data", int'(rdata), int'(e2_dat));
    e2_v = e1_v; e2_rd = e1_rd; e2_mv = e1_mv; e2_dat = e1_dat;
    e1_v = v;
    if (v) begin
      b = n_slot % N;
      e1_br  = b;
      e1_wa  = n_slot % SZ;
      e1_row = (n_slot % ROW) == 0;
      e1_rd  = n_slot >= b * D;
      e1_ra  = (((n_slot - b * D) % SZ) + SZ) % SZ;
      if (b == 0) begin
        e1_dat = d;
        e1_mv  = 1'b1;
      end else begin
        e1_dat = sr[b][b*U-1];
        e1_mv  = fillb[b] >= b * U;
        for (int j = b * U - 1; j > 0; j--) sr[b][j] = sr[b][j-1];
        sr[b][0] = d;
      end
      fillb[b]++;
      n_slot++;
    end
    in_valid = v;
    in_data  = d;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!wr_en && !rd_en && !wr_row_start, "R9", "outputs in reset",
        int'({wr_en, rd_en, wr_row_start}), 0);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    process::self().srandom(32'h5eed_0c1b);
    model_clear();
    @(negedge clk);
    do_reset();
    // First slot after reset: address 0, branch 0 (R9).
    cycle(1'b1, 8'hA5);
    chk(wr_en && wr_addr == '0 && rd_branch == '0, "R9", "first slot",
        int'(wr_addr), 0);
    // Directed: continuous stream through warm-up and several wraps.
    for (int i = 0; i < 199; i++) cycle(1'b1, 8'($urandom));
    // Directed: burst of idle cycles mid-stream.
    for (int i = 0; i < 7; i++) cycle(1'b0, 8'h00);
    // Random gaps.
    for (int i = 0; i < 500; i++) cycle(($urandom % 10) < 6, 8'($urandom));
    // Reset in mid-stream, warm-up must restart.
    do_reset();
    for (int i = 0; i < 60; i++) cycle(1'b1, 8'($urandom));
    for (int i = 0; i < 300; i++) cycle(($urandom % 10) < 8, 8'($urandom));
    cycle(1'b0, 8'h00);
    cycle(1'b0, 8'h00);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule